// File: doc/BRIEF.md
# Error Detect and Capture Unit

This block gathers logical and transport layer error reports for a packet endpoint. Every error class has its own one-cycle detect pulse. With each pulse the block receives fields of the offending packet: a byte address, the source and destination device IDs, and a header information word. Each pulse sets a sticky flag in an error-detect register. An error-enable mask selects which flags drive a level-sensitive maintenance interrupt.

The first enabled error takes a snapshot of the packet fields into three capture registers and then locks them. While they are locked, later errors still set their flags, but they leave the snapshot alone. Software reads the snapshot, then writes zero to the error-detect register. That write re-arms the capture. If an enabled error arrives in the same cycle as the clearing write, it is captured at once.

Software reaches all registers through a 32-bit word port with a combinational read path. Register offsets are: header 0x300, detect 0x308, enable 0x30C, address capture 0x314, device-ID capture 0x318, header-info capture 0x31C.

Top module: `ecu_unit`

## Requirements
- R1: Reset clears the detect, enable and all three capture registers, drives the interrupt low and leaves the capture unlocked, so the first enabled error after reset is captured.
- R2: A detect bit sets on the clock edge after its pulse and clears only by a write to offset 0x308, which loads the written value. A pulse in the same cycle as such a write wins, and its bit ends up set.
- R3: The interrupt output is high exactly while some detect bit and its enable bit are both set. It rises on the edge after an enabled pulse and falls on the edge after the enabled flags are cleared.
- R4: On an enabled error while unlocked, offset 0x314 captures address bits [31:3] with bits [2:0] reading zero. Offset 0x318 captures the destination ID in bits [31:16] and the source ID in bits [15:0]. Offset 0x31C captures the header-info word.
- R5: Once loaded, the capture registers keep their values through any later error until re-armed.
- R6: Writing zero to offset 0x308 unlocks the capture. An enabled error in that same cycle is captured and locks again.
- R7: An error whose enable bit is clear sets its detect bit but neither loads nor locks the capture registers.
- R8: Several enabled errors in one cycle all set their detect bits and produce one snapshot of the packet fields presented in that cycle.
- R9: Offset 0x300 reads the fixed header constant, 32'h0007_0001 by default, and ignores writes. Unmapped offsets read zero. Capture registers ignore writes.
- R10: Offset 0x30C is read/write. It keeps the low NUM_ERR bits of the written value (8 by default) and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | NUM_ERR | One-cycle detect pulse per error class |
| pkt_addr | input | ADDR_W | Byte address of the offending packet |
| pkt_src_id | input | ID_W | Source device ID of the offending packet |
| pkt_dst_id | input | ID_W | Destination device ID of the offending packet |
| pkt_info | input | INFO_W | Header information of the offending packet |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| maint_irq | output | 1 | Maintenance interrupt, level |

## Verification
Two functions can meet in one cycle: the software write that clears the detect register, and a new error pulse. The bench provokes this by driving the write strobe and an error pulse on the same clock.

There are two variants. With an enabled error, the detect bit must survive and the capture must hold the new packet, then stay locked against a later error. With only a disabled error, the flag must survive but the old snapshot must remain, and the next enabled error must still be captured.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

   localparam int WORD_W = 32;
   localparam int MAP_AW = 12;

   localparam logic [MAP_AW-1:0] OFS_HEADER   = 12'h300;
   localparam logic [MAP_AW-1:0] OFS_DETECT   = 12'h308;
   localparam logic [MAP_AW-1:0] OFS_ENABLE   = 12'h30C;
   localparam logic [MAP_AW-1:0] OFS_ADDR_CAP = 12'h314;
   localparam logic [MAP_AW-1:0] OFS_ID_CAP   = 12'h318;
   localparam logic [MAP_AW-1:0] OFS_INFO_CAP = 12'h31C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_HEADER,
      SEL_DETECT,
      SEL_ENABLE,
      SEL_ADDR_CAP,
      SEL_ID_CAP,
      SEL_INFO_CAP
   } reg_sel_e;

endpackage

// File: rtl/ecu_decode.sv
module ecu_decode
   import ecu_pkg::*;
#(
   parameter int REG_AW = 12
) (
   input  logic [REG_AW-1:0] addr,
   output reg_sel_e          sel
);

   localparam int IDX_W = MAP_AW - 2;

   logic             upper_zero;
   logic [IDX_W-1:0] word_idx;
   logic             unused_byte_lanes;

   generate
      if (REG_AW > MAP_AW) begin : g_wide
         assign upper_zero = (addr[REG_AW-1:MAP_AW] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign word_idx          = addr[MAP_AW-1:2];
   assign unused_byte_lanes = ^addr[1:0];

   always_comb begin
      sel = SEL_NONE;
      if (upper_zero) begin
         case (word_idx)
            OFS_HEADER[MAP_AW-1:2]:   sel = SEL_HEADER;
            OFS_DETECT[MAP_AW-1:2]:   sel = SEL_DETECT;
            OFS_ENABLE[MAP_AW-1:2]:   sel = SEL_ENABLE;
            OFS_ADDR_CAP[MAP_AW-1:2]: sel = SEL_ADDR_CAP;
            OFS_ID_CAP[MAP_AW-1:2]:   sel = SEL_ID_CAP;
            OFS_INFO_CAP[MAP_AW-1:2]: sel = SEL_INFO_CAP;
            default:                  sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ecu_detect.sv
module ecu_detect #(
   parameter int NUM_ERR = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] err_pulse,
   input  logic               det_wr,
   input  logic               en_wr,
   input  logic [NUM_ERR-1:0] wdata,
   output logic [NUM_ERR-1:0] detect,
   output logic [NUM_ERR-1:0] enable,
   output logic               hit,
   output logic               irq
);

   // one sticky flag per error class; a pulse outranks a software write
   generate
      for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               detect[i] <= 1'b0;
            end else if (err_pulse[i]) begin
               detect[i] <= 1'b1;
            end else if (det_wr) begin
               detect[i] <= wdata[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= '0;
      end else if (en_wr) begin
         enable <= wdata;
      end
   end

   assign hit = |(err_pulse & enable);
   assign irq = |(detect & enable);

endmodule

// File: rtl/ecu_capture.sv
module ecu_capture #(
   parameter int ADDR_W = 32,
   parameter int ID_W   = 16,
   parameter int INFO_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              rearm,
   input  logic [ADDR_W-1:0] pkt_addr,
   input  logic [ID_W-1:0]   pkt_src_id,
   input  logic [ID_W-1:0]   pkt_dst_id,
   input  logic [INFO_W-1:0] pkt_info,
   output logic              locked,
   output logic [31:0]       cap_addr,
   output logic [31:0]       cap_id,
   output logic [31:0]       cap_info
);

   localparam int ID_PAD = 16 - ID_W;

   logic [31:0] addr_word;
   logic [31:0] id_word;
   logic [31:0] info_word;
   logic        load;
   logic        unused_addr_lo;

   assign unused_addr_lo = ^pkt_addr[2:0];

   // place the packet fields in register layout before storing
   generate
      if (ADDR_W == 32) begin : g_addr_full
         assign addr_word = {pkt_addr[31:3], 3'b000};
      end else begin : g_addr_ext
         assign addr_word = {{(32 - ADDR_W){1'b0}}, pkt_addr[ADDR_W-1:3], 3'b000};
      end

      if (ID_W == 16) begin : g_id_full
         assign id_word = {pkt_dst_id, pkt_src_id};
      end else begin : g_id_ext
         assign id_word = {{ID_PAD{1'b0}}, pkt_dst_id, {ID_PAD{1'b0}}, pkt_src_id};
      end

      if (INFO_W == 32) begin : g_info_full
         assign info_word = pkt_info;
      end else begin : g_info_ext
         assign info_word = {{(32 - INFO_W){1'b0}}, pkt_info};
      end
   endgenerate

   // a clearing write in the same cycle re-opens the window for this error
   assign load = take && (!locked || rearm);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (load) begin
         locked <= 1'b1;
      end else if (rearm) begin
         locked <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_id   <= '0;
         cap_info <= '0;
      end else if (load) begin
         cap_addr <= addr_word;
         cap_id   <= id_word;
         cap_info <= info_word;
      end
   end

endmodule

// File: rtl/ecu_unit.sv
module ecu_unit
   import ecu_pkg::*;
#(
   parameter int          NUM_ERR   = 8,
   parameter int          ADDR_W    = 32,
   parameter int          ID_W      = 16,
   parameter int          INFO_W    = 32,
   parameter int          REG_AW    = 12,
   parameter logic [31:0] HDR_VALUE = 32'h0007_0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] err_pulse,
   input  logic [ADDR_W-1:0]  pkt_addr,
   input  logic [ID_W-1:0]    pkt_src_id,
   input  logic [ID_W-1:0]    pkt_dst_id,
   input  logic [INFO_W-1:0]  pkt_info,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               maint_irq
);

   generate
      if (NUM_ERR < 1 || NUM_ERR > WORD_W) begin : g_bad_num_err
         $error("ecu_unit: NUM_ERR must lie in 1..32");
      end
      if (ADDR_W < 4 || ADDR_W > WORD_W) begin : g_bad_addr_w
         $error("ecu_unit: ADDR_W must lie in 4..32");
      end
      if (ID_W < 1 || ID_W > 16) begin : g_bad_id_w
         $error("ecu_unit: ID_W must lie in 1..16");
      end
      if (INFO_W < 1 || INFO_W > WORD_W) begin : g_bad_info_w
         $error("ecu_unit: INFO_W must lie in 1..32");
      end
      if (REG_AW < MAP_AW) begin : g_bad_reg_aw
         $error("ecu_unit: REG_AW must be at least 12");
      end
   endgenerate

   reg_sel_e           sel;
   logic               det_wr;
   logic               en_wr;
   logic               det_clear;
   logic [NUM_ERR-1:0] det_q;
   logic [NUM_ERR-1:0] en_q;
   logic               hit;
   logic               cap_locked;
   logic [31:0]        cap_addr_w;
   logic [31:0]        cap_id_w;
   logic [31:0]        cap_info_w;
   logic [31:0]        det_word;
   logic [31:0]        en_word;

   ecu_decode #(.REG_AW(REG_AW)) u_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign det_wr    = reg_wr && (sel == SEL_DETECT);
   assign en_wr     = reg_wr && (sel == SEL_ENABLE);
   assign det_clear = det_wr && (reg_wdata == '0);

   ecu_detect #(.NUM_ERR(NUM_ERR)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_pulse (err_pulse),
      .det_wr    (det_wr),
      .en_wr     (en_wr),
      .wdata     (reg_wdata[NUM_ERR-1:0]),
      .detect    (det_q),
      .enable    (en_q),
      .hit       (hit),
      .irq       (maint_irq)
   );

   ecu_capture #(
      .ADDR_W (ADDR_W),
      .ID_W   (ID_W),
      .INFO_W (INFO_W)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (hit),
      .rearm      (det_clear),
      .pkt_addr   (pkt_addr),
      .pkt_src_id (pkt_src_id),
      .pkt_dst_id (pkt_dst_id),
      .pkt_info   (pkt_info),
      .locked     (cap_locked),
      .cap_addr   (cap_addr_w),
      .cap_id     (cap_id_w),
      .cap_info   (cap_info_w)
   );

   generate
      if (NUM_ERR == WORD_W) begin : g_flags_full
         assign det_word = det_q;
         assign en_word  = en_q;
      end else begin : g_flags_ext
         assign det_word = {{(WORD_W - NUM_ERR){1'b0}}, det_q};
         assign en_word  = {{(WORD_W - NUM_ERR){1'b0}}, en_q};
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_HEADER:   reg_rdata = HDR_VALUE;
         SEL_DETECT:   reg_rdata = det_word;
         SEL_ENABLE:   reg_rdata = en_word;
         SEL_ADDR_CAP: reg_rdata = cap_addr_w;
         SEL_ID_CAP:   reg_rdata = cap_id_w;
         SEL_INFO_CAP: reg_rdata = cap_info_w;
         default:      reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
   import ecu_pkg::*;
#(
   parameter int          NUM_ERR   = 8,
   parameter logic [31:0] HDR_VALUE = 32'h0007_0001
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ERR-1:0] err_pulse,
   input logic [NUM_ERR-1:0] detect,
   input logic [NUM_ERR-1:0] enable,
   input logic               det_wr,
   input logic               en_wr,
   input logic               det_clear,
   input logic               locked,
   input logic [31:0]        cap_addr,
   input logic [31:0]        cap_id,
   input reg_sel_e           sel,
   input logic [31:0]        reg_rdata,
   input logic               maint_irq
);

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(det_wr) |-> (($past(detect) & ~detect) == '0));

   // R2
   pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_pulse) |=> ((detect & $past(err_pulse)) == $past(err_pulse)));

   // R3
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(err_pulse & enable)) && !en_wr) |=> maint_irq);

   // R3
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_clear && !(|err_pulse)) |=> !maint_irq);

   // R4
   lock_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && (|(err_pulse & enable))) |=> locked);

   // R5
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !det_clear) |=> ($stable(cap_addr) && $stable(cap_id) && locked));

   // R7
   no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !(|(err_pulse & enable))) |=> !locked);

   // R9
   always_comb begin
      if (rst_n === 1'b1 && sel == SEL_HEADER) begin
         hdr_const_chk: assert (reg_rdata == HDR_VALUE);
      end
   end

endmodule

bind ecu_unit ecu_checker #(
   .NUM_ERR   (NUM_ERR),
   .HDR_VALUE (HDR_VALUE)
) u_ecu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .err_pulse (err_pulse),
   .detect    (det_q),
   .enable    (en_q),
   .det_wr    (det_wr),
   .en_wr     (en_wr),
   .det_clear (det_clear),
   .locked    (cap_locked),
   .cap_addr  (cap_addr_w),
   .cap_id    (cap_id_w),
   .sel       (sel),
   .reg_rdata (reg_rdata),
   .maint_irq (maint_irq)
);

// File: tb/sim_ecu_unit.sv
`timescale 1ns/1ps
module sim_ecu_unit;

   localparam logic [31:0] HDR = 32'h0007_0001;
   localparam int NE = 8;

   localparam logic [1:0] K_WR  = 2'd0;
   localparam logic [1:0] K_RD  = 2'd1;
   localparam logic [1:0] K_ERR = 2'd2;
   localparam logic [1:0] K_IRQ = 2'd3;

   // {kind, requirement, offset, data (write value or pulse mask), expected (read value, or packet tag for K_ERR)}
   localparam int NV = 42;
   localparam logic [81:0] TBL [NV] = '{
      {K_RD,  4'd9,  12'h300, 32'h0,        HDR},            // R9 header
      {K_WR,  4'd9,  12'h300, 32'hFFFF_FFFF, 32'h0},
      {K_RD,  4'd9,  12'h300, 32'h0,        HDR},            // R9 write ignored
      {K_RD,  4'd9,  12'h304, 32'h0,        32'h0},          // R9 unmapped
      {K_RD,  4'd9,  12'h310, 32'h0,        32'h0},          // R9 unmapped
      {K_RD,  4'd1,  12'h308, 32'h0,        32'h0},          // R1
      {K_RD,  4'd1,  12'h30C, 32'h0,        32'h0},          // R1
      {K_RD,  4'd1,  12'h314, 32'h0,        32'h0},          // R1
      {K_RD,  4'd1,  12'h318, 32'h0,        32'h0},          // R1
      {K_IRQ, 4'd1,  12'h000, 32'h0,        32'h0},          // R1
      {K_WR,  4'd10, 12'h30C, 32'hFFFF_FF05, 32'h0},
      {K_RD,  4'd10, 12'h30C, 32'h0,        32'h0000_0005},  // R10
      {K_ERR, 4'd7,  12'h000, 32'h2,        32'hAAAA_1237},
      {K_RD,  4'd7,  12'h308, 32'h0,        32'h0000_0002},  // R7 flag set
      {K_RD,  4'd7,  12'h318, 32'h0,        32'h0},          // R7 no capture
      {K_IRQ, 4'd3,  12'h000, 32'h0,        32'h0},          // R3 disabled only
      {K_ERR, 4'd4,  12'h000, 32'h4,        32'h1234_5679},
      {K_RD,  4'd2,  12'h308, 32'h0,        32'h0000_0006},  // R2
      {K_RD,  4'd4,  12'h314, 32'h0,        32'h1234_5678},  // R4
      {K_RD,  4'd4,  12'h318, 32'h0,        32'h1234_5679},  // R4
      {K_RD,  4'd4,  12'h31C, 32'h0,        32'hEDCB_A986},  // R4
      {K_IRQ, 4'd3,  12'h000, 32'h0,        32'h1},          // R3
      {K_ERR, 4'd5,  12'h000, 32'h1,        32'hDEAD_BEEF},
      {K_RD,  4'd5,  12'h314, 32'h0,        32'h1234_5678},  // R5
      {K_RD,  4'd5,  12'h31C, 32'h0,        32'hEDCB_A986},  // R5
      {K_RD,  4'd2,  12'h308, 32'h0,        32'h0000_0007},  // R2
      {K_WR,  4'd9,  12'h314, 32'hFFFF_FFFF, 32'h0},
      {K_RD,  4'd9,  12'h314, 32'h0,        32'h1234_5678},  // R9 capture read-only
      {K_WR,  4'd6,  12'h308, 32'h0,        32'h0},
      {K_RD,  4'd6,  12'h308, 32'h0,        32'h0},          // R6
      {K_IRQ, 4'd3,  12'h000, 32'h0,        32'h0},          // R3 drop
      {K_RD,  4'd6,  12'h314, 32'h0,        32'h1234_5678},  // R6 clear keeps data
      {K_ERR, 4'd8,  12'h000, 32'h5,        32'hCAFE_F00D},
      {K_RD,  4'd8,  12'h308, 32'h0,        32'h0000_0005},  // R8
      {K_RD,  4'd8,  12'h314, 32'h0,        32'hCAFE_F008},  // R8
      {K_RD,  4'd8,  12'h318, 32'h0,        32'hCAFE_F00D},  // R8
      {K_IRQ, 4'd3,  12'h000, 32'h0,        32'h1},          // R3
      {K_WR,  4'd2,  12'h308, 32'h2,        32'h0},
      {K_RD,  4'd2,  12'h308, 32'h0,        32'h0000_0002},  // R2 write loads value
      {K_IRQ, 4'd3,  12'h000, 32'h0,        32'h0},          // R3
      {K_ERR, 4'd5,  12'h000, 32'h4,        32'h1111_1111},
      {K_RD,  4'd5,  12'h314, 32'h0,        32'hCAFE_F008}   // R5 nonzero write keeps lock
   };

   logic          clk;
   logic          rst_n;
   logic [NE-1:0] err_pulse;
   logic [31:0]   pkt_addr;
   logic [15:0]   pkt_src_id;
   logic [15:0]   pkt_dst_id;
   logic [31:0]   pkt_info;
   logic [11:0]   reg_addr;
   logic          reg_wr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic          maint_irq;

   int  checks   = 0;
   int  failures = 0;
   bit  finished = 0;

   ecu_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_pulse  (err_pulse),
      .pkt_addr   (pkt_addr),
      .pkt_src_id (pkt_src_id),
      .pkt_dst_id (pkt_dst_id),
      .pkt_info   (pkt_info),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .maint_irq  (maint_irq)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // packet fields derive from one tag: dst=tag[31:16], src=tag[15:0], info=~tag
   task automatic set_packet(input logic [NE-1:0] mask, input logic [31:0] tag);
      err_pulse  = mask;
      pkt_addr   = tag;
      pkt_dst_id = tag[31:16];
      pkt_src_id = tag[15:0];
      pkt_info   = ~tag;
   endtask

   task automatic idle_inputs();
      err_pulse = '0;
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic reg_read(input int req, input logic [11:0] a, input logic [31:0] exp, input string what);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp, what);
   endtask

   task automatic inject(input logic [NE-1:0] mask, input logic [31:0] tag);
      @(negedge clk);
      set_packet(mask, tag);
      @(negedge clk);
      idle_inputs();
   endtask

   // write to the detect register and pulse errors in the same cycle
   task automatic clear_with_error(input logic [NE-1:0] mask, input logic [31:0] tag);
      @(negedge clk);
      reg_addr = 12'h308; reg_wdata = 32'h0; reg_wr = 1'b1;
      set_packet(mask, tag);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      reg_addr = '0;
      set_packet('0, 32'h0);
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  kind;
         logic [3:0]  req;
         logic [11:0] ofs;
         logic [31:0] dat;
         logic [31:0] exp;
         {kind, req, ofs, dat, exp} = TBL[i];
         case (kind)
            K_WR:  reg_write(ofs, dat);
            K_RD:  reg_read(int'(req), ofs, exp, $sformatf("row %0d read %h", i, ofs));
            K_ERR: inject(dat[NE-1:0], exp);
            default: begin
               @(negedge clk);
               check(int'(req), {31'b0, maint_irq}, exp, $sformatf("row %0d irq", i));
            end
         endcase
      end

      // R6: clear and enabled error together; new packet captured, then locked
      clear_with_error(8'h01, 32'h0BAD_0010);
      reg_read(2, 12'h308, 32'h0000_0001, "R2 pulse beats clearing write");
      reg_read(6, 12'h314, 32'h0BAD_0010, "R6 same-cycle capture");
      inject(8'h04, 32'h5555_5550);
      reg_read(6, 12'h314, 32'h0BAD_0010, "R6 relocked after same-cycle capture");

      // R7: clear together with a disabled error only; snapshot kept, window open
      clear_with_error(8'h02, 32'h9999_9998);
      reg_read(7, 12'h308, 32'h0000_0002, "R7 disabled flag survives clear");
      reg_read(7, 12'h314, 32'h0BAD_0010, "R7 disabled error does not capture");
      inject(8'h01, 32'h7777_7777);
      reg_read(7, 12'h314, 32'h7777_7770, "R7 window still open after disabled error");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      reg_read(1, 12'h308, 32'h0, "R1 detect after reset");
      reg_read(1, 12'h30C, 32'h0, "R1 enable after reset");
      reg_read(1, 12'h314, 32'h0, "R1 address capture after reset");
      reg_read(1, 12'h31C, 32'h0, "R1 info capture after reset");
      check(1, {31'b0, maint_irq}, 32'h0, "R1 irq after reset");
      reg_write(12'h30C, 32'h1);
      inject(8'h01, 32'h2468_ACE0);
      reg_read(1, 12'h314, 32'h2468_ACE0, "R1 unlocked after reset");

      finish_run();
   end

endmodule